// File: doc/BRIEF.md
# Stochastic Spike Trace and Pair-Based Plasticity Increment

This block keeps two activity traces for a single synapse: one that follows the pre-synaptic neuron and one that follows the post-synaptic neuron. Each trace is a 7-bit unsigned integer. On every time step, marked by a one-cycle strobe, each trace is multiplied by a decay factor of one minus the reciprocal of its time constant. The product is rounded to an integer stochastically, and the trace then adds its impulse if its neuron fired in that step. The sum saturates at the top of the range.

In the same step the block forms a pair-based plasticity increment and sends it to a downstream weight unit. A post-synaptic spike adds the pre-synaptic trace, and a pre-synaptic spike subtracts the post-synaptic trace. The result is read at quarter scale, so pre-before-post timing potentiates and post-before-pre timing depresses. Both time constants and both impulses are run-time inputs and may change from one step to the next. A typical setting is an impulse of 120 with a time constant of 8 on both sides.

Top module: `stdp_trace_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, both traces read 0, `dw` reads 0 and `dw_valid` reads 0.
- R2: In a cycle with `step` low, the spike, impulse and time-constant inputs have no effect: the traces and `dw` hold their values and `dw_valid` is 0.
- R3: On a step, a trace whose neuron did not fire takes the value `lo` or `lo+1`, where `k = x*256 - floor(x*256/tau)`, `lo = floor(k/256)`, and `lo+1` is possible only when `k mod 256` is nonzero. The value is exactly `lo` when `k mod 256` is zero, and it never exceeds the old value `x`.
- R4: On a step, a trace whose neuron fired becomes the decayed value of R3 plus its 7-bit impulse, saturated at 127. It is therefore never below the impulse.
- R5: A time constant of 0 or 1 erases the history: the decayed part is 0, and the trace equals the impulse when the neuron fired and 0 when it did not.
- R6: Rounding up happens with probability equal to the fractional part of `k/256`. A trace of 1 decayed with `tau` 2 rounds up in about half of the steps, and with `tau` 4 in about three quarters of them.
- R7: `dw` is an 8-bit two's-complement value with 2 fractional bits, equal to `(post_spk ? pre_trace_old : 0) - (pre_spk ? post_trace_old : 0)`. Here `_old` means the trace value before the step's update. It is registered and appears, together with a one-cycle `dw_valid` pulse, in the cycle after the strobe.
- R8: With impulse 120 and `tau` 8, a pre spike followed one step later by a post spike gives `dw` = +120 (+30.0). A post trace of 105 met by a pre spike gives `dw` = -105.
- R9: Between steps `dw` keeps the last increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| step | input | 1 | One-cycle strobe that advances the time step |
| pre_spk | input | 1 | Pre-synaptic neuron fired in this step |
| post_spk | input | 1 | Post-synaptic neuron fired in this step |
| pre_imp | input | 7 | Impulse added to the pre trace on a pre spike |
| post_imp | input | 7 | Impulse added to the post trace on a post spike |
| pre_tau | input | 8 | Time constant of the pre trace (0 treated as 1) |
| post_tau | input | 8 | Time constant of the post trace (0 treated as 1) |
| pre_trace | output | 7 | Current pre-synaptic trace |
| post_trace | output | 7 | Current post-synaptic trace |
| dw | output | 8 | Signed weight increment, 2 fractional bits |
| dw_valid | output | 1 | Pulses for one cycle when `dw` is new |

## Verification
The bench drives time constants that make the decay exact, so it can demand precise trace values. Those cases catch a reversed subtraction, a divide by the wrong constant, or an impulse that is added before the decay rather than after it. It overfills a trace (84 decayed by 1/7 plus 60) to catch a design that wraps instead of clamping at 127. It also drives `tau` of 0 and 1, where a design without the zero guard would divide by zero. It checks that `dw` uses the traces from before the update, since using the fresh ones would turn a simultaneous spike pair into the wrong sign or size. It then runs hundreds of one-versus-zero rounding trials, which expose a rounding that always truncates, always rounds up, or compares the fraction the wrong way.

// File: rtl/stdp_trace_pkg.sv
// Package: shared widths and types for the spike-trace block.
// Assumes traces and impulses share one width and that the fixed-point
// product keeps FRAC_W fractional bits.
package stdp_trace_pkg;
    localparam int TRACE_W = 7;
    localparam int TAU_W   = 8;
    localparam int FRAC_W  = 8;
    localparam int LFSR_W  = 16;
    localparam int DW_W    = TRACE_W + 1;

    localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

    typedef logic [TRACE_W-1:0]      trace_t;
    typedef logic [TAU_W-1:0]        tau_t;
    typedef logic signed [DW_W-1:0]  dw_t;
endpackage

// File: rtl/step_lfsr.sv
// Module: Galois LFSR that moves one state per time step and offers its
// low OUT_W bits as a uniform rounding sample.
// Assumes SEED is nonzero and TAPS describes a maximal-length polynomial.
module step_lfsr #(
    parameter int              W     = 16,
    parameter int              OUT_W = 8,
    parameter logic [W-1:0]    TAPS  = 16'hB400,
    parameter logic [W-1:0]    SEED  = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [OUT_W-1:0] sample
);
    logic [W-1:0] state_q;

    // Shift right on each advance, folding the taps back in on a one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else if (adv) begin
            state_q <= (state_q >> 1) ^ (state_q[0] ? TAPS : '0);
        end
    end

    assign sample = state_q[OUT_W-1:0];
endmodule

// File: rtl/trace_unit.sv
// Module: one synaptic trace. On a step it scales the trace by (1 - 1/tau)
// in fixed point, rounds stochastically against its own LFSR, adds the
// impulse on a spike and clamps to the top of the range.
// Assumes tau of 0 means 1 and the impulse is no wider than the trace.
module trace_unit #(
    parameter int                 TRACE_W = 7,
    parameter int                 TAU_W   = 8,
    parameter int                 FRAC_W  = 8,
    parameter int                 LFSR_W  = 16,
    parameter logic [LFSR_W-1:0]  TAPS    = 16'hB400,
    parameter logic [LFSR_W-1:0]  SEED    = 16'hACE1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step,
    input  logic               spike,
    input  logic [TRACE_W-1:0] impulse,
    input  logic [TAU_W-1:0]   tau,
    output logic [TRACE_W-1:0] trace
);
    localparam int PROD_W = TRACE_W + FRAC_W;
    localparam int SUM_W  = TRACE_W + 1;
    localparam logic [TRACE_W-1:0] TOP = {TRACE_W{1'b1}};

    logic [TRACE_W-1:0] trace_q;
    logic [TRACE_W-1:0] trace_d;
    logic [TAU_W-1:0]   tau_eff;
    logic [PROD_W-1:0]  held;
    logic [PROD_W-1:0]  share;
    logic [PROD_W-1:0]  kept;
    logic [FRAC_W-1:0]  sample;
    logic               round_up;
    logic [SUM_W-1:0]   decayed;
    logic [SUM_W-1:0]   total;

    step_lfsr #(
        .W     (LFSR_W),
        .OUT_W (FRAC_W),
        .TAPS  (TAPS),
        .SEED  (SEED)
    ) u_rng (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (step),
        .sample (sample)
    );

    // Decay in fixed point: keep x - x/tau with FRAC_W fractional bits.
    always_comb begin
        tau_eff = (tau == '0) ? TAU_W'(1) : tau;
        held    = {trace_q, {FRAC_W{1'b0}}};
        share   = held / PROD_W'(tau_eff);
        kept    = held - share;
    end

    // Stochastic rounding, impulse addition and clamping at the top.
    always_comb begin
        round_up = kept[FRAC_W-1:0] > sample;
        decayed  = {1'b0, kept[PROD_W-1:FRAC_W]} + SUM_W'(round_up);
        total    = decayed + (spike ? {1'b0, impulse} : '0);
        trace_d  = total[SUM_W-1] ? TOP : total[TRACE_W-1:0];
    end

    // Trace register: moves only on a step strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trace_q <= '0;
        end else if (step) begin
            trace_q <= trace_d;
        end
    end

    assign trace = trace_q;
endmodule

// File: rtl/stdp_increment.sv
// Module: pair-based plasticity increment. A post spike adds the pre trace,
// a pre spike subtracts the post trace; the LSB weighs one quarter.
// Assumes the traces given are the values before this step's update.
module stdp_increment #(
    parameter int TRACE_W = 7,
    parameter int DW_W    = TRACE_W + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   step,
    input  logic                   pre_spk,
    input  logic                   post_spk,
    input  logic [TRACE_W-1:0]     pre_trace,
    input  logic [TRACE_W-1:0]     post_trace,
    output logic signed [DW_W-1:0] dw,
    output logic                   dw_valid
);
    logic signed [DW_W-1:0] potentiate;
    logic signed [DW_W-1:0] depress;
    logic signed [DW_W-1:0] dw_next;

    // Gate each trace with the opposite neuron's dependency flag.
    always_comb begin
        potentiate = post_spk ? DW_W'(pre_trace)  : '0;
        depress    = pre_spk  ? DW_W'(post_trace) : '0;
        dw_next    = potentiate - depress;
    end

    // Output register: new increment and a valid pulse per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dw       <= '0;
            dw_valid <= 1'b0;
        end else begin
            dw_valid <= step;
            if (step) begin
                dw <= dw_next;
            end
        end
    end
endmodule

// File: rtl/stdp_trace_top.sv
// Module: top of the spike-trace block. Two trace units, one per neuron
// side, each with a differently seeded LFSR, plus the increment stage.
// Assumes the step strobe is one cycle wide per time step.
module stdp_trace_top
    import stdp_trace_pkg::*;
#(
    parameter int                TR_W    = TRACE_W,
    parameter int                TC_W    = TAU_W,
    parameter int                FB_W    = FRAC_W,
    parameter int                RNG_W   = LFSR_W,
    parameter logic [RNG_W-1:0]  RNG_SEED = LFSR_SEED,
    parameter logic [RNG_W-1:0]  RNG_TAPS = LFSR_TAPS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  step,
    input  logic                  pre_spk,
    input  logic                  post_spk,
    input  logic [TR_W-1:0]       pre_imp,
    input  logic [TR_W-1:0]       post_imp,
    input  logic [TC_W-1:0]       pre_tau,
    input  logic [TC_W-1:0]       post_tau,
    output logic [TR_W-1:0]       pre_trace,
    output logic [TR_W-1:0]       post_trace,
    output logic signed [TR_W:0]  dw,
    output logic                  dw_valid
);
    localparam int SIDES = 2;

    logic [SIDES-1:0] spk;
    logic [TR_W-1:0]  imp    [SIDES];
    logic [TC_W-1:0]  tau    [SIDES];
    logic [TR_W-1:0]  trace  [SIDES];

    // Gather the two sides into arrays; index 0 is pre, 1 is post.
    always_comb begin
        spk    = {post_spk, pre_spk};
        imp[0] = pre_imp;
        imp[1] = post_imp;
        tau[0] = pre_tau;
        tau[1] = post_tau;
    end

    for (genvar g = 0; g < SIDES; g++) begin : g_side
        trace_unit #(
            .TRACE_W (TR_W),
            .TAU_W   (TC_W),
            .FRAC_W  (FB_W),
            .LFSR_W  (RNG_W),
            .TAPS    (RNG_TAPS),
            .SEED    (RNG_SEED ^ RNG_W'(g * 40503))
        ) u_trace (
            .clk     (clk),
            .rst_n   (rst_n),
            .step    (step),
            .spike   (spk[g]),
            .impulse (imp[g]),
            .tau     (tau[g]),
            .trace   (trace[g])
        );
    end

    assign pre_trace  = trace[0];
    assign post_trace = trace[1];

    stdp_increment #(
        .TRACE_W (TR_W),
        .DW_W    (TR_W + 1)
    ) u_incr (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .pre_spk    (pre_spk),
        .post_spk   (post_spk),
        .pre_trace  (trace[0]),
        .post_trace (trace[1]),
        .dw         (dw),
        .dw_valid   (dw_valid)
    );
endmodule

// File: rtl/stdp_trace_checker.sv
// Module: property checker for the spike-trace block, bound to the top.
// Assumes the top's port names and a 7-bit trace.
module stdp_trace_checker #(
    parameter int TR_W = 7
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  step,
    input logic                  pre_spk,
    input logic                  post_spk,
    input logic [TR_W-1:0]       pre_imp,
    input logic [TR_W-1:0]       post_trace,
    input logic [TR_W-1:0]       pre_trace,
    input logic signed [TR_W:0]  dw,
    input logic                  dw_valid
);
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pre_trace == '0 && post_trace == '0 && dw == '0 && !dw_valid));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !$rose(rst_n)) |=> ($stable(pre_trace) && $stable(post_trace) && $stable(dw) && !dw_valid));

    assert_decay_no_growth_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !pre_spk) |=> (pre_trace <= $past(pre_trace)));

    assert_impulse_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && pre_spk) |=> (pre_trace >= $past(pre_imp)));

    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> dw_valid);

    assert_dw_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (dw == (($past(post_spk) ? {1'b0, $past(pre_trace)} : '0)
                       - ($past(pre_spk) ? {1'b0, $past(post_trace)} : '0))));
endmodule

bind stdp_trace_top stdp_trace_checker #(.TR_W(TR_W)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (step),
    .pre_spk    (pre_spk),
    .post_spk   (post_spk),
    .pre_imp    (pre_imp),
    .post_trace (post_trace),
    .pre_trace  (pre_trace),
    .dw         (dw),
    .dw_valid   (dw_valid)
);

// File: tb/stdp_trace_top_tb.sv
module stdp_trace_top_tb;
    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              step = 1'b0;
    logic              pre_spk = 1'b0;
    logic              post_spk = 1'b0;
    logic [6:0]        pre_imp = '0;
    logic [6:0]        post_imp = '0;
    logic [7:0]        pre_tau = 8'd1;
    logic [7:0]        post_tau = 8'd1;
    logic [6:0]        pre_trace;
    logic [6:0]        post_trace;
    logic signed [7:0] dw;
    logic              dw_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    stdp_trace_top u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .pre_spk    (pre_spk),
        .post_spk   (post_spk),
        .pre_imp    (pre_imp),
        .post_imp   (post_imp),
        .pre_tau    (pre_tau),
        .post_tau   (post_tau),
        .pre_trace  (pre_trace),
        .post_trace (post_trace),
        .dw         (dw),
        .dw_valid   (dw_valid)
    );

    typedef struct packed {
        logic       pspk;
        logic       qspk;
        logic [6:0] pimp;
        logic [6:0] qimp;
        logic [7:0] ptau;
        logic [7:0] qtau;
        logic [6:0] exp_pre;
        logic [6:0] exp_post;
        logic [7:0] exp_dw;
    } vec_t;

    // Exact-decay sequence from reset; see requirement tags per row.
    localparam vec_t VECS [8] = '{
        '{1'b1, 1'b0, 7'd120, 7'd120, 8'd8, 8'd8, 7'd120, 7'd0,   8'd0},   // R4
        '{1'b0, 1'b1, 7'd120, 7'd120, 8'd8, 8'd8, 7'd105, 7'd120, 8'd120}, // R8 potentiation
        '{1'b0, 1'b0, 7'd0,   7'd0,   8'd5, 8'd8, 7'd84,  7'd105, 8'd0},   // R3 exact
        '{1'b1, 1'b0, 7'd60,  7'd0,   8'd7, 8'd5, 7'd127, 7'd84,  8'h97},  // R4 sat, R8 -105
        '{1'b1, 1'b1, 7'd10,  7'd5,   8'd1, 8'd4, 7'd10,  7'd68,  8'd43},  // R5, R7 both
        '{1'b0, 1'b0, 7'd0,   7'd0,   8'd0, 8'd0, 7'd0,   7'd0,   8'd0},   // R5 tau 0
        '{1'b0, 1'b1, 7'd0,   7'd127, 8'd2, 8'd2, 7'd0,   7'd127, 8'd0},   // R4 max impulse
        '{1'b1, 1'b0, 7'd0,   7'd0,   8'd3, 8'd1, 7'd0,   7'd0,   8'h81}   // R7 -127
    };

    task automatic check(input string req, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    // One step: strobe at a falling edge, outputs sampled one cycle later.
    task automatic do_step(input logic ps, input logic qs, input logic [6:0] pi,
                           input logic [6:0] qi, input logic [7:0] pt, input logic [7:0] qt);
        @(negedge clk);
        pre_spk = ps; post_spk = qs; pre_imp = pi; post_imp = qi;
        pre_tau = pt; post_tau = qt; step = 1'b1;
        @(negedge clk);
        step = 1'b0; pre_spk = 1'b0; post_spk = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        int ones_p, ones_q;
        repeat (3) @(negedge clk);
        // R1: state during reset and right after release
        check("R1 pre_trace in reset", int'(pre_trace), 0);
        check("R1 dw_valid in reset", int'(dw_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pre_trace", int'(pre_trace), 0);
        check("R1 post_trace", int'(post_trace), 0);
        check("R1 dw", int'(dw), 0);
        check("R1 dw_valid", int'(dw_valid), 0);

        // Vector table walk
        for (int i = 0; i < 8; i++) begin
            do_step(VECS[i].pspk, VECS[i].qspk, VECS[i].pimp, VECS[i].qimp,
                    VECS[i].ptau, VECS[i].qtau);
            check($sformatf("R3/R4 vec%0d pre_trace", i), int'(pre_trace), int'(VECS[i].exp_pre));
            check($sformatf("R3/R4 vec%0d post_trace", i), int'(post_trace), int'(VECS[i].exp_post));
            check($sformatf("R7/R8 vec%0d dw", i), int'(dw), int'($signed(VECS[i].exp_dw)));
            check($sformatf("R7 vec%0d dw_valid", i), int'(dw_valid), 1);
        end
        @(negedge clk);
        check("R7 dw_valid single cycle", int'(dw_valid), 0);

        // R2 / R9: inputs wiggle with step low; nothing moves
        do_step(1'b0, 1'b1, 7'd0, 7'd100, 8'd1, 8'd1);   // post = 100, dw = 0
        do_step(1'b1, 1'b0, 7'd50, 7'd0, 8'd1, 8'd1);    // pre = 50, dw = -100
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            pre_spk = c[0]; post_spk = ~c[0]; pre_imp = 7'd127; post_imp = 7'd127;
            pre_tau = 8'(c); post_tau = 8'(c + 1);
        end
        @(negedge clk);
        pre_spk = 1'b0; post_spk = 1'b0;
        check("R2 pre_trace held", int'(pre_trace), 50);
        check("R2 post_trace held", int'(post_trace), 0);
        check("R9 dw held", int'(dw), -100);
        check("R2 dw_valid idle", int'(dw_valid), 0);

        // R3: inexact decay stays within floor/ceil (100, tau 3 -> 66 or 67)
        do_step(1'b1, 1'b1, 7'd100, 7'd100, 8'd1, 8'd1);
        do_step(1'b0, 1'b0, 7'd0, 7'd0, 8'd3, 8'd3);
        checks++;
        if (!(pre_trace == 7'd66 || pre_trace == 7'd67)) begin
            errors++;
            $display("FAIL R3 bound pre: actual=%0d expected=66..67", pre_trace);
        end
        checks++;
        if (!(post_trace == 7'd66 || post_trace == 7'd67)) begin
            errors++;
            $display("FAIL R3 bound post: actual=%0d expected=66..67", post_trace);
        end

        // R6: rounding probability (pre tau 2 -> p 0.5, post tau 4 -> p 0.75)
        ones_p = 0; ones_q = 0;
        for (int t = 0; t < 400; t++) begin
            do_step(1'b1, 1'b1, 7'd1, 7'd1, 8'd1, 8'd1);
            do_step(1'b0, 1'b0, 7'd0, 7'd0, 8'd2, 8'd4);
            if (pre_trace > 7'd1 || post_trace > 7'd1) begin
                errors++;
                $display("FAIL R6 range: actual=%0d/%0d expected<=1", pre_trace, post_trace);
            end
            checks++;
            ones_p += int'(pre_trace);
            ones_q += int'(post_trace);
        end
        checks++;
        if (ones_p < 140 || ones_p > 260) begin
            errors++;
            $display("FAIL R6 half: actual=%0d expected=140..260", ones_p);
        end
        checks++;
        if (ones_q < 240 || ones_q > 360) begin
            errors++;
            $display("FAIL R6 three-quarter: actual=%0d expected=240..360", ones_q);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule